// File: doc/BRIEF.md
# Bit-serial frame receive FIFO

This block buffers the payload of a received radio frame one bit at a time. A serial data receiver delivers a bit with each data-clock strobe, and an SPI-side reader removes bits one at a time. Storage is a 256-location, one-bit-wide array with two independent wrapping pointers. Writing is gated by the frame. A frame opens when the pattern detector reports a sync match. It closes on end-of-message, which also locks the buffer, or on loss of sync. Because the reader may start right after sync, reception and readout can overlap. A frame longer than the array fits only if the reader keeps pace.

The block reports the number of unread valid bits and a sticky overflow flag. A control state machine can re-initialise it with an explicit command. It can also be set to re-initialise automatically when a new frame syncs. In the extended two-pattern sync mode, one marker bit is stored ahead of the payload to record which pattern matched.

Top module: `bit_frame_rx_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears everything: `valid_cnt` 0, `overflow` 0, `locked` 0, and `rd_bit` 0.
- R2: When no frame is open, `rx_strobe` stores nothing and `valid_cnt` does not change.
- R3: A `sync_det` pulse in the idle state opens a frame from the next cycle on. Each `rx_strobe` in an open frame stores `rx_bit` and raises `valid_cnt` by one. Bits come out on `rd_bit` in the order they were written.
- R4: An `eom` pulse in an open frame closes it and sets `locked` from the next cycle. A strobe in the same cycle as `eom` is dropped. While locked, `rx_strobe` and `sync_det` have no effect, and `locked` stays high until init.
- R5: A `sync_lost` pulse in an open frame closes it without setting `locked`. A strobe in that cycle is dropped, and a later `sync_det` opens a new frame that appends to the stored bits.
- R6: Both pointers wrap from 255 to 0. A stream longer than 256 bits, read concurrently, keeps its order.
- R7: `valid_cnt` counts unread bits in the range 0 to 256. A cycle with both an accepted write and an accepted read leaves it unchanged.
- R8: A write while 256 unread bits are held (and no read in the same cycle) discards the bit and sets `overflow`. The flag stays set until init.
- R9: `rd_bit` is 0 when `valid_cnt` is 0. A read strobe then leaves the count and read position unchanged.
- R10: `init_cmd` takes priority over all other inputs. On the next cycle it gives count 0, overflow 0, locked 0, and no open frame.
- R11: With `auto_init_en` high, a `sync_det` that opens a frame first discards all stored bits and clears `overflow`.
- R12: With `ext_mode` high, the cycle of the opening `sync_det` stores one marker bit equal to `sync_alt` ahead of the payload. `sync_alt` is 0 for the first pattern and 1 for the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| init_cmd | input | 1 | Re-initialise pointers, flags and frame state |
| auto_init_en | input | 1 | Re-initialise when a new frame syncs |
| ext_mode | input | 1 | Store a pattern-marker bit ahead of the payload |
| sync_det | input | 1 | Sync pattern detected (one-cycle pulse) |
| sync_alt | input | 1 | Which pattern matched, valid with `sync_det` |
| eom | input | 1 | End of message |
| sync_lost | input | 1 | Receiver lost synchronisation |
| rx_strobe | input | 1 | Receiver data-clock strobe |
| rx_bit | input | 1 | Received data bit |
| rd_strobe | input | 1 | SPI-side read strobe, consumes `rd_bit` |
| rd_bit | output | 1 | Oldest unread bit, 0 when empty |
| valid_cnt | output | 9 | Number of unread valid bits |
| overflow | output | 1 | Sticky overflow flag |
| locked | output | 1 | Frame ended at end-of-message |

## Verification
The assertions assume that every control input is a clean single-cycle strobe sampled on the rising edge, with no X values once reset is released. They also assume that `sync_alt` matters only together with `sync_det`. The stimulus drives all inputs one time unit after a rising edge and returns each strobe to zero after one cycle. It never leaves an input undriven. The bench also exercises the combinations the design must order correctly: a read and a write in the same cycle, writes at full occupancy, and reads on an empty buffer.

// File: rtl/bfr_pkg.sv
// Package: shared types for the bit-serial frame receive FIFO.
// Assumes: nothing; holds only type definitions.
package bfr_pkg;
    typedef enum logic [1:0] {
        FRM_IDLE   = 2'd0,
        FRM_ACTIVE = 2'd1,
        FRM_LOCKED = 2'd2
    } frame_state_e;
endpackage

// File: rtl/bfr_ptr.sv
// Module: wrapping up-counter used as a bit address pointer.
// Assumes: clear has priority; when clear and inc coincide the pointer
// lands on 1 (the bit written at address 0 during that same cycle).
module bfr_ptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);
    // Advance, wrap naturally at the top, or restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (clear)
            ptr <= ADDR_W'(inc);
        else if (inc)
            ptr <= ptr + ADDR_W'(1);
    end
endmodule

// File: rtl/bfr_bitmem.sv
// Module: bit-addressable storage with one write port and one
// asynchronous read port, built as an array of enabled cells.
// Assumes: waddr/raddr are in range by construction (2**ADDR_W cells).
module bfr_bitmem #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] cells;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        // One storage bit, loaded when the decoded write address selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[i] <= 1'b0;
            else if (we && (waddr == ADDR_W'(i)))
                cells[i] <= wdata;
        end
    end

    // Read multiplexer selecting the addressed bit.
    always_comb rdata = cells[raddr];
endmodule

// File: rtl/bfr_frame_ctrl.sv
// Module: frame gating. Decides when received bits may be written,
// inserts the pattern-marker bit, and tracks idle/active/locked.
// Assumes: strobes are single-cycle; init_cmd outranks everything.
module bfr_frame_ctrl
    import bfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_cmd,
    input  logic auto_init_en,
    input  logic ext_mode,
    input  logic sync_det,
    input  logic sync_alt,
    input  logic eom,
    input  logic sync_lost,
    input  logic rx_strobe,
    input  logic rx_bit,
    output logic clear,
    output logic wr_req,
    output logic wr_data,
    output logic locked
);
    frame_state_e state, state_nxt;
    logic         start;
    logic         rx_take;

    // Decode the start of a frame, the clear request and the write request.
    always_comb begin
        start   = sync_det && (state == FRM_IDLE) && !init_cmd;
        clear   = init_cmd || (start && auto_init_en);
        rx_take = (state == FRM_ACTIVE) && rx_strobe && !eom
                  && !sync_lost && !init_cmd;
        if (start && ext_mode) begin
            wr_req  = 1'b1;
            wr_data = sync_alt;
        end else begin
            wr_req  = rx_take;
            wr_data = rx_bit;
        end
    end

    // Next frame state; end-of-message wins over sync loss.
    always_comb begin
        state_nxt = state;
        if (init_cmd)
            state_nxt = FRM_IDLE;
        else if (start)
            state_nxt = FRM_ACTIVE;
        else if (state == FRM_ACTIVE && eom)
            state_nxt = FRM_LOCKED;
        else if (state == FRM_ACTIVE && sync_lost)
            state_nxt = FRM_IDLE;
    end

    // Frame state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= FRM_IDLE;
        else
            state <= state_nxt;
    end

    // Lock output follows the locked state.
    always_comb locked = (state == FRM_LOCKED);
endmodule

// File: rtl/bfr_occupancy.sv
// Module: tracks unread bit count and the sticky overflow flag, and
// grants writes and reads.
// Assumes: a read in the same cycle frees a slot for a write at full.
module bfr_occupancy #(
    parameter int ADDR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            wr_req,
    input  logic            rd_strobe,
    output logic            wr_ok,
    output logic            rd_ok,
    output logic [ADDR_W:0] count,
    output logic            overflow
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;

    logic full, empty;

    // Grant logic for the two ports.
    always_comb begin
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
        rd_ok = rd_strobe && !empty && !clear;
        wr_ok = wr_req && (clear || !full || rd_ok);
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= CNT_W'(wr_ok);
        else if (wr_ok && !rd_ok)
            count <= count + CNT_W'(1);
        else if (rd_ok && !wr_ok)
            count <= count - CNT_W'(1);
    end

    // Sticky overflow, cleared only by init.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (clear)
            overflow <= 1'b0;
        else if (wr_req && !wr_ok)
            overflow <= 1'b1;
    end
endmodule

// File: rtl/bit_frame_rx_fifo.sv
// Module: top of the bit-serial frame receive FIFO. Connects frame
// gating, occupancy, the two pointers and the bit store.
// Assumes: all control inputs are synchronous single-cycle strobes.
module bit_frame_rx_fifo #(
    parameter int ADDR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_cmd,
    input  logic            auto_init_en,
    input  logic            ext_mode,
    input  logic            sync_det,
    input  logic            sync_alt,
    input  logic            eom,
    input  logic            sync_lost,
    input  logic            rx_strobe,
    input  logic            rx_bit,
    input  logic            rd_strobe,
    output logic            rd_bit,
    output logic [ADDR_W:0] valid_cnt,
    output logic            overflow,
    output logic            locked
);
    logic              clear, wr_req, wr_data, wr_ok, rd_ok, mem_out;
    logic [ADDR_W-1:0] wptr, rptr, waddr;

    bfr_frame_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd),
        .auto_init_en(auto_init_en), .ext_mode(ext_mode),
        .sync_det(sync_det), .sync_alt(sync_alt), .eom(eom),
        .sync_lost(sync_lost), .rx_strobe(rx_strobe), .rx_bit(rx_bit),
        .clear(clear), .wr_req(wr_req), .wr_data(wr_data), .locked(locked)
    );

    bfr_occupancy #(.ADDR_W(ADDR_W)) u_occ (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_req(wr_req),
        .rd_strobe(rd_strobe), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .count(valid_cnt), .overflow(overflow)
    );

    bfr_ptr #(.ADDR_W(ADDR_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .inc(wr_ok), .ptr(wptr)
    );

    bfr_ptr #(.ADDR_W(ADDR_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .inc(rd_ok), .ptr(rptr)
    );

    // A write coinciding with a clear lands at address zero.
    always_comb waddr = clear ? '0 : wptr;

    bfr_bitmem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(waddr),
        .wdata(wr_data), .raddr(rptr), .rdata(mem_out)
    );

    // Present the head bit only when something is stored.
    always_comb rd_bit = (valid_cnt != '0) && mem_out;
endmodule

// File: rtl/bit_frame_rx_fifo_chk.sv
// Module: assertion checker bound to the FIFO top.
// Assumes: inputs are clean synchronous strobes after reset.
module bit_frame_rx_fifo_chk #(
    parameter int ADDR_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            init_cmd,
    input logic            auto_init_en,
    input logic            sync_det,
    input logic            rx_strobe,
    input logic            rd_strobe,
    input logic            rd_bit,
    input logic [ADDR_W:0] valid_cnt,
    input logic            overflow,
    input logic            locked
);
    localparam int DEPTH = 1 << ADDR_W;

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(valid_cnt) <= DEPTH);

    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_cnt == '0) |-> (rd_bit == 1'b0));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !init_cmd && !(sync_det && auto_init_en)) |=> overflow);

    a_r4_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !init_cmd) |=> locked);

    a_r4_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !init_cmd) |=> (valid_cnt <= $past(valid_cnt)));

    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_strobe && !rd_strobe && !init_cmd && !sync_det) |=> $stable(valid_cnt));

    a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_cmd && !(sync_det && auto_init_en)) |=>
        ((int'(valid_cnt) <= int'($past(valid_cnt)) + 1) &&
         (int'(valid_cnt) + 1 >= int'($past(valid_cnt)))));

    a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd |=> (valid_cnt == '0 && !overflow && !locked));
endmodule

bind bit_frame_rx_fifo bit_frame_rx_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd),
    .auto_init_en(auto_init_en), .sync_det(sync_det),
    .rx_strobe(rx_strobe), .rd_strobe(rd_strobe), .rd_bit(rd_bit),
    .valid_cnt(valid_cnt), .overflow(overflow), .locked(locked)
);

// File: tb/tb_bit_frame_rx_fifo.sv
module tb_bit_frame_rx_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_cmd = 0, auto_init_en = 0, ext_mode = 0;
    logic       sync_det = 0, sync_alt = 0, eom = 0, sync_lost = 0;
    logic       rx_strobe = 0, rx_bit = 0, rd_strobe = 0;
    logic       rd_bit, overflow, locked;
    logic [8:0] valid_cnt;

    int total = 0;
    int bad   = 0;

    bit_frame_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd),
        .auto_init_en(auto_init_en), .ext_mode(ext_mode),
        .sync_det(sync_det), .sync_alt(sync_alt), .eom(eom),
        .sync_lost(sync_lost), .rx_strobe(rx_strobe), .rx_bit(rx_bit),
        .rd_strobe(rd_strobe), .rd_bit(rd_bit), .valid_cnt(valid_cnt),
        .overflow(overflow), .locked(locked)
    );

    always #4 clk = ~clk;

    // Behavioural reference: queue of bits, frame state 0 idle/1 open/2 locked.
    bit mq[$];
    int mst  = 0;
    bit movf = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); mst = 0; movf = 0;
        end else begin
            bit start, clr, want, wb;
            start = sync_det && mst == 0 && !init_cmd;
            clr   = init_cmd || (start && auto_init_en);
            want  = 0; wb = 0;
            if (start && ext_mode) begin want = 1; wb = sync_alt; end
            else if (mst == 1 && rx_strobe && !eom && !sync_lost && !init_cmd) begin
                want = 1; wb = rx_bit;
            end
            if (clr) begin mq.delete(); movf = 0; end
            else if (rd_strobe && mq.size() != 0) void'(mq.pop_front());
            if (want) begin
                if (mq.size() < 256) mq.push_back(wb);
                else movf = 1;
            end
            if (init_cmd) mst = 0;
            else if (start) mst = 1;
            else if (mst == 1 && eom) mst = 2;
            else if (mst == 1 && sync_lost) mst = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the reference on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 count", int'(valid_cnt), mq.size());
            chk("R8 overflow", int'(overflow), int'(movf));
            chk("R4 locked", int'(locked), int'(mst == 2));
            chk("R3 head bit", int'(rd_bit), mq.size() != 0 ? int'(mq[0]) : 0);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask
    task automatic push(input logic b);
        rx_strobe = 1; rx_bit = b; tick(); rx_strobe = 0;
    endtask
    task automatic pop(output logic b);
        b = rd_bit; rd_strobe = 1; tick(); rd_strobe = 0;
    endtask
    task automatic pushpop(input logic b, output logic o);
        o = rd_bit; rd_strobe = 1; rx_strobe = 1; rx_bit = b; tick();
        rd_strobe = 0; rx_strobe = 0;
    endtask
    task automatic do_sync(input logic alt);
        sync_det = 1; sync_alt = alt; tick(); sync_det = 0; sync_alt = 0;
    endtask
    task automatic do_eom();  eom = 1; tick(); eom = 0; endtask
    task automatic do_lost(); sync_lost = 1; tick(); sync_lost = 0; endtask
    task automatic do_init(); init_cmd = 1; tick(); init_cmd = 0; endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R3 watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic b;
        bit   exq[$];
        repeat (3) tick();
        rst_n = 1; tick();
        chk("R1 count", int'(valid_cnt), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 locked", int'(locked), 0);
        chk("R1 rd_bit", int'(rd_bit), 0);

        repeat (3) push(1);
        chk("R2 idle strobes ignored", int'(valid_cnt), 0);

        do_sync(0);
        for (int i = 0; i < 8; i++) push(logic'((8'hB2 >> (7 - i)) & 1));
        chk("R3 count after 8", int'(valid_cnt), 8);
        for (int i = 0; i < 8; i++) begin
            pop(b);
            chk("R3 order", int'(b), int'((8'hB2 >> (7 - i)) & 1));
        end
        chk("R3 drained", int'(valid_cnt), 0);

        chk("R9 empty rd_bit", int'(rd_bit), 0);
        pop(b);
        chk("R9 empty read count", int'(valid_cnt), 0);
        chk("R9 empty read value", int'(b), 0);

        push(1); push(0);
        pushpop(1, b);
        chk("R7 simultaneous count", int'(valid_cnt), 2);
        chk("R7 simultaneous read value", int'(b), 1);

        eom = 1; rx_strobe = 1; rx_bit = 1; tick(); eom = 0; rx_strobe = 0;
        chk("R4 locked after eom", int'(locked), 1);
        chk("R4 strobe with eom dropped", int'(valid_cnt), 2);
        push(1);
        do_sync(1);
        chk("R4 ignored while locked", int'(valid_cnt), 2);
        chk("R4 still locked", int'(locked), 1);
        pop(b); chk("R4 read while locked", int'(b), 0);

        do_init();
        chk("R10 count cleared", int'(valid_cnt), 0);
        chk("R10 unlocked", int'(locked), 0);
        push(1);
        chk("R10 no frame after init", int'(valid_cnt), 0);

        do_sync(0);
        push(1); push(1); push(0);
        sync_lost = 1; rx_strobe = 1; rx_bit = 1; tick(); sync_lost = 0; rx_strobe = 0;
        push(1);
        chk("R5 stopped on loss", int'(valid_cnt), 3);
        chk("R5 not locked", int'(locked), 0);
        do_sync(0); push(1);
        chk("R5 new frame appends", int'(valid_cnt), 4);
        do_init();

        do_sync(0);
        for (int i = 0; i < 256; i++) push(logic'(((i >> 3) ^ i) & 1));
        chk("R8 full count", int'(valid_cnt), 256);
        chk("R8 no overflow at full", int'(overflow), 0);
        push(1);
        chk("R8 overflow set", int'(overflow), 1);
        chk("R8 count held", int'(valid_cnt), 256);
        for (int i = 0; i < 256; i++) begin
            pop(b);
            if (i == 0 || i == 255) chk("R8 stored data", int'(b), ((i >> 3) ^ i) & 1);
        end
        chk("R8 overflow sticky", int'(overflow), 1);
        do_init();
        chk("R10 overflow cleared", int'(overflow), 0);

        do_sync(0);
        for (int i = 0; i < 10; i++) begin
            push(logic'(i % 3 == 0)); exq.push_back(bit'(i % 3 == 0));
        end
        for (int i = 10; i < 610; i++) begin
            bit e;
            e = exq.pop_front();
            pushpop(logic'(i % 3 == 0), b);
            exq.push_back(bit'(i % 3 == 0));
            if (int'(b) != int'(e)) chk("R6 wrapped order", int'(b), int'(e));
        end
        chk("R6 wrapped order tail", int'(rd_bit), int'(exq[0]));
        chk("R6 count after stream", int'(valid_cnt), 10);
        do_init();

        ext_mode = 1;
        do_sync(1);
        chk("R12 marker count", int'(valid_cnt), 1);
        chk("R12 marker second pattern", int'(rd_bit), 1);
        push(0);
        pop(b); pop(b);
        chk("R12 payload after marker", int'(b), 0);
        do_init();
        do_sync(0);
        chk("R12 marker first pattern count", int'(valid_cnt), 1);
        chk("R12 marker first pattern", int'(rd_bit), 0);
        do_init();
        ext_mode = 0;

        auto_init_en = 1;
        do_sync(0);
        repeat (5) push(1);
        do_lost();
        chk("R11 kept after loss", int'(valid_cnt), 5);
        do_sync(0);
        chk("R11 cleared on sync", int'(valid_cnt), 0);
        push(1);
        chk("R11 fresh frame", int'(valid_cnt), 1);
        chk("R11 fresh head", int'(rd_bit), 1);
        auto_init_en = 0;
        do_init();

        rst_n = 0; tick(); tick();
        chk("R1 reset count", int'(valid_cnt), 0);
        rst_n = 1; tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule